// File: doc/BRIEF.md
# Test Vector Pattern Sequencer

This block runs a small pattern program held in an external pattern memory and turns it into a stream of test vectors. Each vector is a word of per-pin waveform character indices, `CW` bits for each of `PINS` pins. The pin formatters downstream turn these indices into waveforms. A vector is released only on a period strobe from the timing generator, so the block produces at most one vector per tester period. Control instructions take one clock each and do not wait for a strobe. The program can select the waveform table, stage pin values for the next vector, nest counted loops, spin in a match loop on an external compare result, jump, change only chosen pins at a segment boundary, and stop.

Each pattern word has three fields. A 4-bit opcode sits at the top. Below it is a `PINS`-bit pin mask, and the lowest `PINS*CW` bits hold data. A start pulse begins execution at address 0. A stop, a loop-stack overflow or an exhausted match loop ends the run. Any of these sets the done output and drives the pins to the termination word. Done stays set until the next start.

Top module: `pat_seq`

## Requirements
- R1: After reset, `vec_out` equals `TERM`, `mem_addr` is 0, and `done`, `timeout`, `ovf_err` and `tbl_sel` are 0. A `start` pulse restarts execution at address 0 and clears `done`, `timeout` and `ovf_err`.
- R2: Word fields: opcode in bits [IW-1:IW-4], pin mask in bits [DW+PINS-1:DW], data in bits [DW-1:0]. Pin i uses data bits [i*CW +: CW]. A vector (opcode 1) takes effect only on a cycle with `strobe` high. On that cycle `vec_out` takes the data field for every pin in the mask, `vec_valid` pulses for one cycle, and execution moves to the next address.
- R3: A table-select word (opcode 2) loads `tbl_sel` from data bits [TW-1:0]. All later vectors are emitted under that value until another table-select word appears.
- R4: A condition word (opcode 3) stages the data of its masked pins without changing `vec_out`. On the next vector, staged pins that the vector does not mask take the staged value. Pins that neither the vector nor the staged set names keep their previous value. The staged set is then cleared.
- R5: A loop word (opcode 4, count N in data bits [CNTW-1:0]) runs the words up to its matching end-loop word (opcode 5) N times. A count of 0 runs the body once. Loops nest up to `DEPTH` levels.
- R6: A goto word (opcode 8) continues execution at the address held in data bits [AW-1:0].
- R7: A stop word (opcode 15) sets `done` and drives `vec_out` to `TERM`. Both stay unchanged until the next `start`.
- R8: A match-loop word (opcode 6, limit L in data bits [CNTW-1:0]) repeats its body up to its end word (opcode 7). Execution leaves the loop when `match` is high as that end word executes. With L=0 there is no bound. With L>0, the L-th pass that ends without a match sets `timeout` and stops as in R7.
- R9: A loop word that finds `DEPTH` levels already open sets `ovf_err` and stops as in R7.
- R10: A breakpoint word (opcode 9) waits for `strobe` and then changes only its masked pins to its data. All other pins hold, and `vec_valid` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin execution at address 0 |
| strobe | input | 1 | Tester period strobe |
| match | input | 1 | External compare result for match loops |
| mem_addr | output | AW | Pattern memory read address |
| mem_data | input | 4+PINS+PINS*CW | Pattern word at `mem_addr` (combinational read) |
| vec_out | output | PINS*CW | Per-pin waveform character indices |
| vec_valid | output | 1 | One-cycle pulse when a vector or breakpoint is applied |
| tbl_sel | output | TW | Active waveform table |
| done | output | 1 | Run finished |
| timeout | output | 1 | Match loop hit its limit without a match |
| ovf_err | output | 1 | Loop stack overflow |

## Verification
The bench builds the block with its defaults (4 pins of 2-bit indices, 6-bit addresses, 8-bit counts, a 4-deep loop stack) except for a termination word of 0xC3. A nonzero termination word makes the stop drive visible against the all-zero data the programs use. The 4-deep stack means a fifth nested loop reaches the overflow path in a few words. The 8-bit count field allows small match-loop limits such as 2, so the timeout path is reached within a few strobes. The strobe arrives every fourth clock, which separates the one-clock control words from the strobe-paced vectors.

// File: rtl/pat_seq.sv
module pat_seq #(
  parameter int PINS  = 4,
  parameter int CW    = 2,
  parameter int AW    = 6,
  parameter int CNTW  = 8,
  parameter int DEPTH = 4,
  parameter int TW    = 2,
  parameter logic [PINS*CW-1:0] TERM = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     strobe,
  input  logic                     match,
  output logic [AW-1:0]            mem_addr,
  input  logic [4+PINS+PINS*CW-1:0] mem_data,
  output logic [PINS*CW-1:0]       vec_out,
  output logic                     vec_valid,
  output logic [TW-1:0]            tbl_sel,
  output logic                     done,
  output logic                     timeout,
  output logic                     ovf_err
);
  localparam int DW  = PINS * CW;
  localparam int IW  = 4 + PINS + DW;
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SPW = $clog2(DEPTH + 1);

  localparam logic [3:0] OP_VEC  = 4'd1;
  localparam logic [3:0] OP_TBL  = 4'd2;
  localparam logic [3:0] OP_COND = 4'd3;
  localparam logic [3:0] OP_LOOP = 4'd4;
  localparam logic [3:0] OP_ENDL = 4'd5;
  localparam logic [3:0] OP_MLP  = 4'd6;
  localparam logic [3:0] OP_ENDM = 4'd7;
  localparam logic [3:0] OP_GOTO = 4'd8;
  localparam logic [3:0] OP_BRK  = 4'd9;
  localparam logic [3:0] OP_STOP = 4'd15;

  function automatic logic [DW-1:0] expand(input logic [PINS-1:0] m);
    for (int i = 0; i < PINS; i++) expand[i*CW +: CW] = {CW{m[i]}};
  endfunction

  logic [AW-1:0]   pc;
  logic            running;
  logic [PINS-1:0] cmask;
  logic [DW-1:0]   cdata;
  logic [SPW-1:0]  sp;
  logic [AW-1:0]   st_pc  [DEPTH];
  logic [CNTW-1:0] st_cnt [DEPTH];
  logic [AW-1:0]   m_start;
  logic [CNTW-1:0] m_lim, m_iter;

  wire [3:0]      op    = mem_data[IW-1 -: 4];
  wire [PINS-1:0] fmask = mem_data[DW +: PINS];
  wire [DW-1:0]   fdata = mem_data[DW-1:0];
  wire [CNTW-1:0] fcnt  = fdata[CNTW-1:0];
  wire [DW-1:0]   vexp  = expand(fmask);
  wire [DW-1:0]   cexp  = expand(cmask);
  wire [IXW-1:0]  tix   = IXW'(sp - SPW'(1));
  wire [IXW-1:0]  pix   = IXW'(sp);
  wire [AW-1:0]   pc_nx = pc + AW'(1);
  wire            full  = (sp == SPW'(DEPTH));
  wire            lim_hit = (m_lim != '0) &&
                            (({1'b0, m_iter} + (CNTW+1)'(1)) == {1'b0, m_lim});

  wire [DW-1:0] vec_nx = (fdata & vexp) | (cdata & cexp & ~vexp) | (vec_out & ~vexp & ~cexp);
  wire [DW-1:0] brk_nx = (vec_out & ~vexp) | (fdata & vexp);

  logic halt;
  always_comb begin
    halt = 1'b0;
    if (running && !start)
      halt = (op == OP_STOP) || (op == OP_LOOP && full) ||
             (op == OP_ENDM && !match && lim_hit);
  end

  assign mem_addr = pc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; running <= 1'b0; done <= 1'b0; timeout <= 1'b0; ovf_err <= 1'b0;
      vec_out <= TERM; vec_valid <= 1'b0; tbl_sel <= '0;
      cmask <= '0; cdata <= '0; sp <= '0;
      m_start <= '0; m_lim <= '0; m_iter <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        st_pc[i] <= '0; st_cnt[i] <= '0;
      end
    end else begin
      vec_valid <= 1'b0;
      if (start) begin
        pc <= '0; running <= 1'b1; done <= 1'b0; timeout <= 1'b0; ovf_err <= 1'b0;
        tbl_sel <= '0; cmask <= '0; sp <= '0; m_iter <= '0; m_lim <= '0;
      end else if (halt) begin
        running <= 1'b0;
        done    <= 1'b1;
        vec_out <= TERM;
        if (op == OP_LOOP) ovf_err <= 1'b1;
        if (op == OP_ENDM) timeout <= 1'b1;
      end else if (running) begin
        case (op)
          OP_VEC: if (strobe) begin
            vec_out <= vec_nx; vec_valid <= 1'b1; cmask <= '0; pc <= pc_nx;
          end
          OP_BRK: if (strobe) begin
            vec_out <= brk_nx; vec_valid <= 1'b1; pc <= pc_nx;
          end
          OP_TBL: begin
            tbl_sel <= fdata[TW-1:0]; pc <= pc_nx;
          end
          OP_COND: begin
            cdata <= (cdata & ~vexp) | (fdata & vexp);
            cmask <= cmask | fmask;
            pc    <= pc_nx;
          end
          OP_LOOP: begin
            st_pc[pix]  <= pc_nx;
            st_cnt[pix] <= (fcnt == '0) ? '0 : fcnt - CNTW'(1);
            sp <= sp + SPW'(1);
            pc <= pc_nx;
          end
          OP_ENDL: begin
            if (sp == '0) pc <= pc_nx;
            else if (st_cnt[tix] != '0) begin
              st_cnt[tix] <= st_cnt[tix] - CNTW'(1);
              pc <= st_pc[tix];
            end else begin
              sp <= sp - SPW'(1);
              pc <= pc_nx;
            end
          end
          OP_MLP: begin
            m_start <= pc_nx; m_lim <= fcnt; m_iter <= '0; pc <= pc_nx;
          end
          OP_ENDM: begin
            if (match) pc <= pc_nx;
            else begin
              m_iter <= m_iter + CNTW'(1);
              pc <= m_start;
            end
          end
          OP_GOTO: pc <= fdata[AW-1:0];
          default: pc <= pc_nx;
        endcase
      end
    end
  end

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);
  a_r7_stop_term: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> vec_out == TERM);
  a_r8_timeout_stops: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> done);
  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SPW'(DEPTH));
  a_r2_vec_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(strobe));
  a_r4_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!vec_valid && !done) |-> $stable(vec_out));
endmodule

// File: tb/pat_seq_tb.sv
module pat_seq_tb;
  localparam int PINS = 4, CW = 2, AW = 6, DW = 8, IW = 16;
  localparam logic [7:0] TERM = 8'hC3;

  logic clk = 0, rst_n = 0, start = 0, strobe = 0, match = 0;
  logic [AW-1:0] mem_addr;
  logic [IW-1:0] mem_data;
  logic [DW-1:0] vec_out;
  logic vec_valid, done, timeout, ovf_err;
  logic [1:0] tbl_sel;
  logic [IW-1:0] mem [64];

  int checks = 0, fails = 0, nvec = 0;
  bit arm = 0;
  logic [7:0] got [32];
  logic [1:0] gtb [32];

  always #2 clk = ~clk;
  assign mem_data = mem[mem_addr];

  pat_seq #(.PINS(PINS), .CW(CW), .AW(AW), .CNTW(8), .DEPTH(4), .TW(2), .TERM(TERM)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .strobe(strobe), .match(match),
    .mem_addr(mem_addr), .mem_data(mem_data), .vec_out(vec_out), .vec_valid(vec_valid),
    .tbl_sel(tbl_sel), .done(done), .timeout(timeout), .ovf_err(ovf_err));

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph = (ph + 1) % 4;
      strobe = (ph == 0);
    end
  end

  always @(negedge clk) if (vec_valid) begin
    if (nvec < 32) begin got[nvec] = vec_out; gtb[nvec] = tbl_sel; end
    nvec++;
    if (arm && nvec >= 3) match = 1;
  end

  function automatic logic [IW-1:0] w(input logic [3:0] op, input logic [3:0] m, input logic [7:0] d);
    return {op, m, d};
  endfunction

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic clr;
    for (int i = 0; i < 64; i++) mem[i] = w(4'd15, 4'h0, 8'h00);
    nvec = 0; arm = 0; match = 0;
  endtask

  task automatic run;
    bit fin = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done) begin fin = 1; break; end
      @(negedge clk);
    end
    chk(fin, "R7 watchdog", fin, 1);
  endtask

  task automatic chk_seq(input string r, input int n, input logic [7:0] e [32]);
    chk(nvec == n, {r, " count"}, nvec, n);
    for (int i = 0; i < n && i < 32; i++) chk(got[i] == e[i], r, got[i], e[i]);
  endtask

  task automatic t_reset;
    chk(vec_out == TERM, "R1 reset vec", vec_out, TERM);
    chk(mem_addr == 0, "R1 reset addr", mem_addr, 0);
    chk({done, timeout, ovf_err} == 0, "R1 reset flags", {done, timeout, ovf_err}, 0);
    chk(tbl_sel == 0, "R1 reset table", tbl_sel, 0);
  endtask

  task automatic t_basic;
    logic [7:0] e [32];
    clr();
    mem[0] = w(2, 4'hF, 8'h02);
    mem[1] = w(1, 4'hF, 8'hE4);
    mem[2] = w(3, 4'h1, 8'h02);
    mem[3] = w(1, 4'hE, 8'h1B);
    mem[4] = w(1, 4'h2, 8'h00);
    mem[5] = w(3, 4'h8, 8'hC0);
    mem[6] = w(1, 4'hF, 8'h00);
    mem[7] = w(1, 4'h0, 8'hFF);
    mem[8] = w(2, 4'hF, 8'h01);
    mem[9] = w(1, 4'hF, 8'h77);
    e[0] = 8'hE4; e[1] = 8'h1A; e[2] = 8'h12; e[3] = 8'h00; e[4] = 8'h00; e[5] = 8'h77;
    run();
    chk_seq("R2 R4 vectors with condition", 6, e);
    chk(gtb[0] == 2 && gtb[4] == 2, "R3 first table", gtb[4], 2);
    chk(gtb[5] == 1, "R3 switched table", gtb[5], 1);
    chk(vec_out == TERM, "R7 termination", vec_out, TERM);
    repeat (10) @(negedge clk);
    chk(done == 1 && vec_out == TERM, "R7 done held", done, 1);
  endtask

  task automatic t_loops;
    logic [7:0] e [32];
    clr();
    mem[0] = w(4, 0, 8'd2); mem[1] = w(1, 4'hF, 8'h11);
    mem[2] = w(4, 0, 8'd3); mem[3] = w(1, 4'hF, 8'h22);
    mem[4] = w(5, 0, 0);    mem[5] = w(5, 0, 0);
    mem[6] = w(4, 0, 8'd0); mem[7] = w(1, 4'hF, 8'h33);
    mem[8] = w(5, 0, 0);
    foreach (e[i]) e[i] = 8'h22;
    e[0] = 8'h11; e[4] = 8'h11; e[8] = 8'h33;
    run();
    chk_seq("R5 nested loops", 9, e);
  endtask

  task automatic t_goto;
    logic [7:0] e [32];
    clr();
    mem[0] = w(1, 4'hF, 8'h01); mem[1] = w(8, 0, 8'd4);
    mem[2] = w(1, 4'hF, 8'hAA); mem[3] = w(1, 4'hF, 8'hBB);
    mem[4] = w(1, 4'hF, 8'h05);
    e[0] = 8'h01; e[1] = 8'h05;
    run();
    chk_seq("R6 goto", 2, e);
  endtask

  task automatic t_match_free;
    logic [7:0] e [32];
    clr();
    arm = 1;
    mem[0] = w(6, 0, 8'd0); mem[1] = w(1, 4'hF, 8'h40);
    mem[2] = w(7, 0, 0);    mem[3] = w(1, 4'hF, 8'h09);
    e[0] = 8'h40; e[1] = 8'h40; e[2] = 8'h40; e[3] = 8'h09;
    run();
    chk_seq("R8 match exit", 4, e);
    chk(timeout == 0, "R8 no timeout", timeout, 0);
  endtask

  task automatic t_match_limit;
    logic [7:0] e [32];
    clr();
    mem[0] = w(6, 0, 8'd2); mem[1] = w(1, 4'hF, 8'h40);
    mem[2] = w(7, 0, 0);    mem[3] = w(1, 4'hF, 8'h09);
    e[0] = 8'h40; e[1] = 8'h40;
    run();
    chk_seq("R8 limited passes", 2, e);
    chk(timeout == 1, "R8 timeout", timeout, 1);
    chk(vec_out == TERM, "R8 stop on timeout", vec_out, TERM);
  endtask

  task automatic t_overflow;
    clr();
    for (int i = 0; i < 5; i++) mem[i] = w(4, 0, 8'd2);
    mem[5] = w(1, 4'hF, 8'h11);
    run();
    chk(ovf_err == 1, "R9 overflow flag", ovf_err, 1);
    chk(nvec == 0, "R9 no vector", nvec, 0);
  endtask

  task automatic t_brk;
    logic [7:0] e [32];
    clr();
    mem[0] = w(1, 4'hF, 8'h00); mem[1] = w(9, 4'h4, 8'hFF);
    mem[2] = w(1, 4'h0, 8'h00);
    e[0] = 8'h00; e[1] = 8'h30; e[2] = 8'h30;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    chk({done, ovf_err, timeout} == 0, "R1 start clears flags", {done, ovf_err, timeout}, 0);
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    chk_seq("R10 breakpoint", 3, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_loops();
    t_goto();
    t_match_free();
    t_match_limit();
    t_overflow();
    t_brk();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule